// File: doc/BRIEF.md
# Vectored Eight-Source Interrupt Controller

This block gathers eight hardware interrupt conditions for a small system-on-chip and presents them to a processor. Each source has a fixed trigger type. Sources 0, 2 and 3 are level-type. Sources 1, 4, 5, 6 and 7 are edge-type.

A pending bit is latched in a status register only when the source's enable bit is set. The controller drives one maskable request line and a separate non-maskable line that is armed for a low-battery input. Software reaches the block through a byte-wide port that has an address, a write strobe and combinational read data.

Reading the vector register returns a programmable 5-bit base in the upper bits. The lower three bits hold the index of the highest pending source. An interrupt handler uses this word to select its table entry, and then clears the source by writing a one to its bit in the acknowledge register.

Top module: `vic_ctrl`

## Requirements
- R1: A write to address 0xB0 stores write bits 7..3 as the vector base and discards bits 2..0. A read of 0xB0 returns the base in bits 7..3.
- R2: Bits 2..0 of a 0xB0 read equal the index of the highest set status bit. They are 0 when the status register is clear.
- R3: A level-type source (index 0, 2 or 3) sets its status bit on every clock edge at which its condition and its enable bit are both 1. The status register reads at 0xB4.
- R4: An edge-type source (index 1, 4, 5, 6 or 7) sets its status bit only at the edge where its condition was 0 on the previous edge and is 1 now, with enable set. A condition that stays high does not set the bit again after an acknowledge.
- R5: The enable mask is read and written at 0xB2. While an enable bit is 0, its source never sets the matching status bit.
- R6: Writing 0xB6 clears every status bit written as 1 and leaves bits written as 0 unchanged. If a level source is active and enabled at that same edge, its bit stays 1.
- R7: A status bit stays set when its enable bit is cleared or its condition drops. Only an acknowledge clears it.
- R8: irq_o is the OR of all status bits, registered. It rises one clock after the first status bit is set.
- R9: Bit 4 of address 0xB7 arms the non-maskable output. nmi_o is 1 one clock after an edge at which that bit and batt_low_i are both 1. A read of 0xB7 returns that bit in position 4 and zeros elsewhere.
- R10: After reset, the base, mask, status, NMI arm and both outputs are 0. A condition that is already high when reset ends does not count as an edge.
- R11: Writes to 0xB4 and to unmapped addresses change no state. Reads of 0xB6 and of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | 8 | Register address |
| wr_en_i | input | 1 | Write strobe, one clock per write |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Combinational read data for addr_i |
| cond_in | input | 8 | Raw interrupt conditions, one per source |
| batt_low_i | input | 1 | Low-battery condition |
| irq_o | output | 1 | Maskable interrupt request |
| nmi_o | output | 1 | Non-maskable interrupt request |

## Verification
Two functions can act on the same status bit at the same clock edge: an acknowledge write that clears the bit, and a new set from its source. The bench forces this collision in two directed cases. In the first, it acknowledges level source 0 while its condition is still high, and the status read must stay 1. In the second, it acknowledges edge source 4 while its input stays high, and the bit must clear and stay clear. The random phase then overlaps acknowledge writes with toggling conditions and enable changes, and each read is compared with a bench model in which a set at the same edge wins over a clear.

// File: rtl/vic_pkg.sv
package vic_pkg;

  // Register addresses decoded by the processor-side bus
  localparam logic [7:0] VIC_A_VEC  = 8'hB0;
  localparam logic [7:0] VIC_A_MASK = 8'hB2;
  localparam logic [7:0] VIC_A_STAT = 8'hB4;
  localparam logic [7:0] VIC_A_ACK  = 8'hB6;
  localparam logic [7:0] VIC_A_NMI  = 8'hB7;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_VEC,
    SEL_MASK,
    SEL_STAT,
    SEL_ACK,
    SEL_NMI
  } vic_sel_e;

  function automatic vic_sel_e vic_decode(input logic [7:0] a);
    vic_sel_e s;
    case (a)
      VIC_A_VEC:  s = SEL_VEC;
      VIC_A_MASK: s = SEL_MASK;
      VIC_A_STAT: s = SEL_STAT;
      VIC_A_ACK:  s = SEL_ACK;
      VIC_A_NMI:  s = SEL_NMI;
      default:    s = SEL_NONE;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/vic_regs.sv
// Writable configuration: vector base (R1), enable mask (R5), NMI arm (R9),
// plus the one-cycle acknowledge strobe vector (R6).
module vic_regs
  import vic_pkg::*;
#(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned NSRC    = 8,
  parameter int unsigned OFS_W   = 5,
  parameter int unsigned NMI_BIT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  vic_sel_e          sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic [OFS_W-1:0]  offset_q,
  output logic [NSRC-1:0]   mask_q,
  output logic              nmi_en_q,
  output logic [NSRC-1:0]   ack_vec
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      offset_q <= '0;
      mask_q   <= '0;
      nmi_en_q <= 1'b0;
    end else if (wr_en) begin
      case (sel)
        SEL_VEC:  offset_q <= wr_data[DATA_W-1 -: OFS_W];
        SEL_MASK: mask_q   <= wr_data[NSRC-1:0];
        SEL_NMI:  nmi_en_q <= wr_data[NMI_BIT];
        default:  ;
      endcase
    end
  end

  // Acknowledge is a pulse, not a stored register
  assign ack_vec = (wr_en && sel == SEL_ACK) ? wr_data[NSRC-1:0] : '0;

endmodule

// File: rtl/vic_src_cell.sv
// One interrupt source: trigger qualification and its pending bit.
module vic_src_cell #(
  parameter bit IS_LEVEL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cond,
  input  logic en,
  input  logic ack,
  output logic pend,
  output logic set_evt
);

  logic trig;

  generate
    if (IS_LEVEL) begin : g_level
      // R3: set on every enabled cycle the condition is present
      assign trig = cond;
    end else begin : g_edge
      // R4, R10: previous level tracked without reset, so it holds the
      // input seen during reset and no false edge appears afterwards
      logic prev_q;
      always_ff @(posedge clk) begin
        prev_q <= cond;
      end
      assign trig = cond & ~prev_q;
    end
  endgenerate

  // R5: enable gates the setting of status, not just the output
  assign set_evt = trig & en;

  // R6/R7: only acknowledge clears; a simultaneous set wins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= 1'b0;
    else        pend <= (pend & ~ack) | set_evt;
  end

endmodule

// File: rtl/vic_out_stage.sv
// Registered request outputs (R8, R9).
module vic_out_stage #(
  parameter int unsigned NSRC = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] stat,
  input  logic            nmi_en,
  input  logic            batt_low,
  output logic            irq_q,
  output logic            nmi_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      nmi_q <= 1'b0;
    end else begin
      irq_q <= |stat;
      nmi_q <= nmi_en & batt_low;
    end
  end

endmodule

// File: rtl/vic_ctrl.sv
// Vectored eight-source interrupt controller, top level.
module vic_ctrl
  import vic_pkg::*;
#(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned NSRC       = 8,
  parameter logic [7:0]  LEVEL_MASK = 8'b0000_1101,
  parameter int unsigned NMI_BIT    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic [NSRC-1:0]   cond_in,
  input  logic              batt_low_i,
  output logic              irq_o,
  output logic              nmi_o
);

  localparam int unsigned IDX_W = $clog2(NSRC);
  localparam int unsigned OFS_W = DATA_W - IDX_W;

  // R2: index of the highest set bit, zero when none
  function automatic logic [IDX_W-1:0] top_pending(input logic [NSRC-1:0] s);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (s[i]) r = IDX_W'(i);
    end
    return r;
  endfunction

  // R1/R2: base in the upper bits, pending index in the lower bits
  function automatic logic [DATA_W-1:0] vec_word(input logic [OFS_W-1:0] o,
                                                 input logic [NSRC-1:0]  s);
    return {o, top_pending(s)};
  endfunction

  vic_sel_e           sel;
  logic [OFS_W-1:0]   offset_q;
  logic [NSRC-1:0]    mask_q;
  logic               nmi_en_q;
  logic [NSRC-1:0]    ack_vec;
  logic [NSRC-1:0]    stat_q;
  logic [NSRC-1:0]    set_evt;

  assign sel = vic_decode(addr_i);

  vic_regs #(
    .DATA_W (DATA_W),
    .NSRC   (NSRC),
    .OFS_W  (OFS_W),
    .NMI_BIT(NMI_BIT)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en_i),
    .sel     (sel),
    .wr_data (wr_data_i),
    .offset_q(offset_q),
    .mask_q  (mask_q),
    .nmi_en_q(nmi_en_q),
    .ack_vec (ack_vec)
  );

  generate
    for (genvar i = 0; i < NSRC; i++) begin : g_src
      vic_src_cell #(
        .IS_LEVEL(LEVEL_MASK[i])
      ) u_cell (
        .clk    (clk),
        .rst_n  (rst_n),
        .cond   (cond_in[i]),
        .en     (mask_q[i]),
        .ack    (ack_vec[i]),
        .pend   (stat_q[i]),
        .set_evt(set_evt[i])
      );
    end
  endgenerate

  vic_out_stage #(
    .NSRC(NSRC)
  ) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .stat    (stat_q),
    .nmi_en  (nmi_en_q),
    .batt_low(batt_low_i),
    .irq_q   (irq_o),
    .nmi_q   (nmi_o)
  );

  // Read mux; status is read-only, acknowledge reads as zero (R11)
  always_comb begin
    rd_data_o = '0;
    case (sel)
      SEL_VEC:  rd_data_o = vec_word(offset_q, stat_q);
      SEL_MASK: rd_data_o[NSRC-1:0] = mask_q;
      SEL_STAT: rd_data_o[NSRC-1:0] = stat_q;
      SEL_NMI:  rd_data_o[NMI_BIT] = nmi_en_q;
      default:  rd_data_o = '0;
    endcase
  end

endmodule

// File: rtl/vic_ctrl_chk.sv
module vic_ctrl_chk
  import vic_pkg::*;
#(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned NSRC       = 8,
  parameter logic [7:0]  LEVEL_MASK = 8'b0000_1101,
  parameter int unsigned OFS_W      = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [7:0]        addr_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic [NSRC-1:0]   cond_in,
  input logic              batt_low_i,
  input logic              irq_o,
  input logic              nmi_o,
  input logic [NSRC-1:0]   stat_q,
  input logic [NSRC-1:0]   mask_q,
  input logic [NSRC-1:0]   ack_vec,
  input logic              nmi_en_q,
  input logic [OFS_W-1:0]  offset_q
);

  localparam int unsigned IDX_W = DATA_W - OFS_W;

  logic [IDX_W-1:0] rd_idx;
  assign rd_idx = rd_data_o[IDX_W-1:0];

  a_r1_vec_base: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_i == VIC_A_VEC) |-> (rd_data_o[DATA_W-1 -: OFS_W] == offset_q))
    else $error("a_r1_vec_base");

  a_r2_vec_highest: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_i == VIC_A_VEC && stat_q != '0) |-> ((stat_q >> rd_idx) == NSRC'(1)))
    else $error("a_r2_vec_highest");

  a_r2_vec_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_i == VIC_A_VEC && stat_q == '0) |-> (rd_idx == '0))
    else $error("a_r2_vec_idle");

  a_r8_irq_set: assert property (@(posedge clk) disable iff (!rst_n)
    (|stat_q) |=> irq_o)
    else $error("a_r8_irq_set");

  a_r8_irq_clr: assert property (@(posedge clk) disable iff (!rst_n)
    !(|stat_q) |=> !irq_o)
    else $error("a_r8_irq_clr");

  a_r9_nmi_set: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_en_q && batt_low_i) |=> nmi_o)
    else $error("a_r9_nmi_set");

  a_r9_nmi_clr: assert property (@(posedge clk) disable iff (!rst_n)
    !(nmi_en_q && batt_low_i) |=> !nmi_o)
    else $error("a_r9_nmi_clr");

  generate
    for (genvar i = 0; i < NSRC; i++) begin : g_bit
      // R5: a status bit only rises after an enabled active condition
      a_r5_gated_set: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_q[i]) |-> $past(cond_in[i] && mask_q[i]))
        else $error("a_r5_gated_set bit %0d", i);

      // R7: a status bit only falls after an acknowledge of that bit
      a_r7_clear_by_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stat_q[i]) |-> $past(ack_vec[i]))
        else $error("a_r7_clear_by_ack bit %0d", i);

      if (LEVEL_MASK[i]) begin : g_lvl
        // R3/R6: active enabled level source is pending next cycle
        a_r3_level_hold: assert property (@(posedge clk) disable iff (!rst_n)
          (cond_in[i] && mask_q[i]) |=> stat_q[i])
          else $error("a_r3_level_hold bit %0d", i);
      end
    end
  endgenerate

endmodule

bind vic_ctrl vic_ctrl_chk #(
  .DATA_W    (DATA_W),
  .NSRC      (NSRC),
  .LEVEL_MASK(LEVEL_MASK),
  .OFS_W     (OFS_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .addr_i    (addr_i),
  .rd_data_o (rd_data_o),
  .cond_in   (cond_in),
  .batt_low_i(batt_low_i),
  .irq_o     (irq_o),
  .nmi_o     (nmi_o),
  .stat_q    (stat_q),
  .mask_q    (mask_q),
  .ack_vec   (ack_vec),
  .nmi_en_q  (nmi_en_q),
  .offset_q  (offset_q)
);

// File: tb/vic_ctrl_tb.sv
`timescale 1ns/1ps
module vic_ctrl_tb_top;

  localparam logic [7:0] LVL = 8'b0000_1101;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] addr_i = 8'h00;
  logic       wr_en_i = 1'b0;
  logic [7:0] wr_data_i = 8'h00;
  logic [7:0] rd_data_o;
  logic [7:0] cond_in = 8'h00;
  logic       batt_low_i = 1'b0;
  logic       irq_o;
  logic       nmi_o;

  always #4 clk = ~clk;  // 125 MHz

  vic_ctrl dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr_i    (addr_i),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .rd_data_o (rd_data_o),
    .cond_in   (cond_in),
    .batt_low_i(batt_low_i),
    .irq_o     (irq_o),
    .nmi_o     (nmi_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // Bench model state
  logic [4:0] m_ofs;
  logic [7:0] m_en, m_stat, m_prev;
  logic       m_nmi_en, m_irq, m_nmi;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] hi_idx(input logic [7:0] s);
    for (int k = 7; k >= 0; k--) begin
      if (s[k]) return 3'(k);
    end
    return 3'd0;
  endfunction

  function automatic logic [7:0] exp_read(input logic [7:0] a);
    case (a)
      8'hB0:   return {m_ofs, hi_idx(m_stat)};
      8'hB2:   return m_en;
      8'hB4:   return m_stat;
      8'hB7:   return {3'b000, m_nmi_en, 4'b0000};
      default: return 8'h00;
    endcase
  endfunction

  function automatic string tag_of(input logic [7:0] a);
    case (a)
      8'hB0:   return "R2";
      8'hB2:   return "R5";
      8'hB4:   return "R3";
      8'hB7:   return "R9";
      default: return "R11";
    endcase
  endfunction

  // One clock: drive a bus cycle, advance the model, check the outputs
  task automatic step(input bit w, input logic [7:0] a, input logic [7:0] d);
    logic [7:0] set, ack, n_stat;
    logic       n_irq, n_nmi;
    set = (cond_in & m_en & LVL) | (cond_in & ~m_prev & m_en & ~LVL);
    ack = (w && a == 8'hB6) ? d : 8'h00;
    n_stat = (m_stat & ~ack) | set;
    n_irq = |m_stat;
    n_nmi = m_nmi_en & batt_low_i;
    addr_i = a;
    wr_data_i = d;
    wr_en_i = w;
    @(posedge clk);
    #1;
    m_stat = n_stat;
    m_irq = n_irq;
    m_nmi = n_nmi;
    m_prev = cond_in;
    if (w) begin
      case (a)
        8'hB0: m_ofs = d[7:3];
        8'hB2: m_en = d;
        8'hB7: m_nmi_en = d[4];
        default: ;
      endcase
    end
    wr_en_i = 1'b0;
    chk("R8 irq_o", {7'd0, irq_o}, {7'd0, m_irq});
    chk("R9 nmi_o", {7'd0, nmi_o}, {7'd0, m_nmi});
  endtask

  task automatic idle();
    step(1'b0, 8'h00, 8'h00);
  endtask

  task automatic rdchk(input string tag, input logic [7:0] a, input logic [7:0] exp);
    addr_i = a;
    #1;
    chk(tag, rd_data_o, exp);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    r = $urandom(32'h5EED_1234);
    // R10: edge input 1 held high through reset
    cond_in = 8'h02;
    repeat (5) @(posedge clk);
    #1;
    rst_n = 1'b1;
    m_ofs = '0; m_en = '0; m_stat = '0; m_prev = cond_in;
    m_nmi_en = 1'b0; m_irq = 1'b0; m_nmi = 1'b0;
    rdchk("R10 base", 8'hB0, 8'h00);
    rdchk("R10 mask", 8'hB2, 8'h00);
    rdchk("R10 status", 8'hB4, 8'h00);
    rdchk("R10 nmi arm", 8'hB7, 8'h00);
    chk("R10 irq_o", {7'd0, irq_o}, 8'h00);
    chk("R10 nmi_o", {7'd0, nmi_o}, 8'h00);
    step(1'b1, 8'hB2, 8'hFF);
    idle();
    rdchk("R10 no false edge", 8'hB4, 8'h00);

    // R1: low write bits ignored
    step(1'b1, 8'hB0, 8'hAF);
    rdchk("R1 base", 8'hB0, 8'hA8);

    // R3 level source 0
    cond_in = 8'h03;
    idle();
    rdchk("R3 level set", 8'hB4, 8'h01);
    idle();
    chk("R8 irq after set", {7'd0, irq_o}, 8'h01);
    // R6: acknowledge collides with active level
    step(1'b1, 8'hB6, 8'h01);
    rdchk("R6 level reset wins", 8'hB4, 8'h01);
    cond_in = 8'h02;
    idle();
    rdchk("R7 cond drop keeps", 8'hB4, 8'h01);
    step(1'b1, 8'hB6, 8'h01);
    rdchk("R6 ack clears", 8'hB4, 8'h00);

    // R4 edge source 4
    cond_in = 8'h12;
    idle();
    rdchk("R4 edge set", 8'hB4, 8'h10);
    step(1'b1, 8'hB6, 8'h10);
    rdchk("R4 ack while high", 8'hB4, 8'h00);
    idle();
    rdchk("R4 no re-set while high", 8'hB4, 8'h00);

    // R2 vector with two pending
    cond_in = 8'h03;
    idle();
    cond_in = 8'h13;
    idle();
    rdchk("R2 two pending", 8'hB4, 8'h11);
    rdchk("R2 vector", 8'hB0, 8'hAC);
    cond_in = 8'h02;
    idle();
    step(1'b1, 8'hB6, 8'hFF);
    rdchk("R2 vector idle", 8'hB0, 8'hA8);

    // R5 disabled source
    step(1'b1, 8'hB2, 8'hDF);
    cond_in = 8'h22;
    idle();
    cond_in = 8'h02;
    idle();
    rdchk("R5 masked no set", 8'hB4, 8'h00);
    rdchk("R5 mask read", 8'hB2, 8'hDF);

    // R7 disable keeps pending
    cond_in = 8'h42;
    idle();
    step(1'b1, 8'hB2, 8'h00);
    idle();
    rdchk("R7 disable keeps", 8'hB4, 8'h40);
    rdchk("R2 vector six", 8'hB0, 8'hAE);

    // R11 status is read-only
    step(1'b1, 8'hB4, 8'h00);
    rdchk("R11 status write ignored", 8'hB4, 8'h40);
    step(1'b1, 8'h5A, 8'hFF);
    rdchk("R11 unmapped write", 8'hB2, 8'h00);
    rdchk("R11 ack reads zero", 8'hB6, 8'h00);
    step(1'b1, 8'hB6, 8'h40);
    rdchk("R6 clear bit six", 8'hB4, 8'h00);

    // R9 non-maskable path
    step(1'b1, 8'hB7, 8'hFF);
    rdchk("R9 arm read", 8'hB7, 8'h10);
    batt_low_i = 1'b1;
    idle();
    idle();
    chk("R9 nmi high", {7'd0, nmi_o}, 8'h01);
    step(1'b1, 8'hB7, 8'hEF);
    idle();
    chk("R9 nmi low", {7'd0, nmi_o}, 8'h00);
    rdchk("R9 disarm read", 8'hB7, 8'h00);
    batt_low_i = 1'b0;

    // R8 latency of one clock
    step(1'b1, 8'hB2, 8'hFF);
    cond_in = 8'h82;
    idle();
    rdchk("R8 status bit seven", 8'hB4, 8'h80);
    chk("R8 irq not yet", {7'd0, irq_o}, 8'h00);
    idle();
    chk("R8 irq one later", {7'd0, irq_o}, 8'h01);
    step(1'b1, 8'hB6, 8'hFF);

    // Random phase
    for (int n = 0; n < 3000; n++) begin
      logic [7:0] ra;
      logic [7:0] raddr;
      r = $urandom;
      cond_in = cond_in ^ (r[7:0] & r[15:8] & r[23:16]);
      if (r[31:28] == 4'h0) batt_low_i = ~batt_low_i;
      ra = 8'($urandom);
      case ($urandom % 10)
        0: step(1'b1, 8'hB2, ra);
        1, 2: step(1'b1, 8'hB6, ra);
        3: step(1'b1, 8'hB0, ra);
        4: step(1'b1, 8'hB7, ra);
        5: step(1'b1, 8'hB4, ra);
        6: step(1'b1, 8'($urandom), ra);
        default: idle();
      endcase
      case ($urandom % 6)
        0: raddr = 8'hB0;
        1: raddr = 8'hB2;
        2: raddr = 8'hB4;
        3: raddr = 8'hB7;
        4: raddr = 8'hB6;
        default: raddr = 8'h3C;
      endcase
      rdchk(tag_of(raddr), raddr, exp_read(raddr));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule